// File: doc/BRIEF.md
# Write Completion Poll Controller

This block runs on the host side of a byte-wide nonvolatile memory that finishes its writes internally. Once a write has been issued elsewhere, the host pulses `start_i` with the address it wrote, the byte it wrote and a cycle limit. The controller then reads that location over a request/acknowledge port until the memory reports that the write is over. It can judge progress in one of two ways, chosen per operation by `mode_i`:
- **Data-poll**: bit 7 of a read is compared against bit 7 of the expected byte.
- **Toggle**: bit 6 of each read is compared against bit 6 of the read before it.

The internal write ends at a moment that is unrelated to the host clock, so a single read can report completion falsely. For this reason a possible completion is never taken on trust. The controller first waits a settle interval, which applies in data-poll mode only. It then reads the same location twice more, and each of those reads must return the whole expected byte. If either one does not, polling starts again. A programmable limit on busy cycles stops an operation that never completes. The controller reports the outcome as a one-cycle `done_o` or `timeout_o` pulse.

Top module: `wcp_poll_ctrl`

## Requirements
- R1: After reset, and until a start is accepted, `busy_o`, `rd_req_o`, `done_o` and `timeout_o` are all 0.
- R2: In idle, a high `start_i` is accepted, and `addr_i`, `exp_data_i`, `mode_i` and `limit_i` are captured. `busy_o` rises in the next cycle. Every read of the operation is issued at the captured address. A `start_i` that arrives while busy has no effect on the address, timing or outcome.
- R3: In data-poll mode (`mode_i`=0), a poll read whose bit 7 equals bit 7 of the expected byte is a possible completion. Any other poll read leads to another poll read.
- R4: In data-poll mode, a possible completion is followed by exactly SETTLE_CYC cycles with `rd_req_o` low before the first confirming read is requested.
- R5: In toggle mode (`mode_i`=1), the first poll read after a start or after a rejection only records bit 6. Each later poll read is a possible completion when its bit 6 equals bit 6 of the poll read just before it.
- R6: After a possible completion, two confirming reads follow. When both return a byte equal to the full expected byte, the operation completes.
- R7: If either confirming read differs from the expected byte, polling resumes at once. In toggle mode the recorded bit 6 is discarded as well.
- R8: `done_o` is high for exactly one cycle, the cycle after the acknowledge of the second confirming read. `busy_o` is low in that same cycle.
- R9: Let L be the captured limit. If the operation has not completed by its (L+1)-th busy cycle, it ends and `timeout_o` is high for one cycle in the next cycle. If completion falls in that (L+1)-th cycle, completion wins. `done_o` and `timeout_o` are never high together.
- R10: `rd_req_o` stays high until a cycle with `rd_ack_i` high. `rd_data_i` is taken only in that cycle. `rd_ack_i` is ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start a completion poll (accepted only when idle) |
| mode_i | input | 1 | 0 = data-poll on bit 7, 1 = toggle on bit 6 |
| addr_i | input | ADDR_W | Address of the location just written |
| exp_data_i | input | 8 | Byte that was written |
| limit_i | input | LIMIT_W | Busy-cycle limit L; timeout after L+1 busy cycles |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 8 | Read data |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: write completion confirmed |
| timeout_o | output | 1 | One-cycle pulse: limit reached without completion |

## Verification
The bench memory acknowledges each request one cycle after it first appears. As a result, every read takes two busy cycles, and the data-poll settle adds exactly SETTLE_CYC cycles on top. A successful operation therefore lasts a known number of busy cycles: twice the number of reads, plus SETTLE_CYC for each data-poll candidate. `done_o` or `timeout_o` then follows in the very next cycle. A behavioural model in the bench advances on the same rising edge as the design. Every output is compared with that model on the falling edge, so every result is checked in the cycle it is due. Each scenario is also checked by its total busy length and its final outcome, which are worked out by hand from those counts.

// File: rtl/wcp_pkg.sv
package wcp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_POLL   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_CONF_A = 3'd3,
    ST_CONF_B = 3'd4
  } wcp_state_e;

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } wcp_mode_e;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned POLL_BIT   = 7;
  localparam int unsigned TOGGLE_BIT = 6;

endpackage

// File: rtl/wcp_rst_sync.sv
module wcp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/wcp_match_eval.sv
module wcp_match_eval
  import wcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wcp_mode_e         mode,
  input  logic [BYTE_W-1:0] exp_byte,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic              capture,
  input  logic              clr_hist,
  output logic              candidate,
  output logic              full_match
);

  logic prev_bit_q, prev_bit_d;
  logic have_prev_q, have_prev_d;

  always_comb begin
    prev_bit_d  = prev_bit_q;
    have_prev_d = have_prev_q;
    if (clr_hist) begin
      have_prev_d = 1'b0;
    end else if (capture) begin
      prev_bit_d  = rd_byte[TOGGLE_BIT];
      have_prev_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_bit_q  <= 1'b0;
      have_prev_q <= 1'b0;
    end else begin
      prev_bit_q  <= prev_bit_d;
      have_prev_q <= have_prev_d;
    end
  end

  always_comb begin
    if (mode == MODE_DATA) begin
      candidate = (rd_byte[POLL_BIT] == exp_byte[POLL_BIT]);
    end else begin
      candidate = have_prev_q && (rd_byte[TOGGLE_BIT] == prev_bit_q);
    end
  end

  assign full_match = (rd_byte == exp_byte);

endmodule

// File: rtl/wcp_settle_timer.sv
module wcp_settle_timer #(
  parameter int unsigned SETTLE_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  generate
    if (SETTLE_CYC == 0) begin : g_none
      assign expired = 1'b1;
    end else begin : g_count
      localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
      localparam logic [SW-1:0] LAST = SW'(SETTLE_CYC - 1);
      logic [SW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (load) begin
          cnt_d = '0;
        end else if (run && (cnt_q != LAST)) begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign expired = run && (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/wcp_limit_counter.sv
module wcp_limit_counter #(
  parameter int unsigned LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LIMIT_W-1:0] limit,
  input  logic               run,
  output logic               hit
);

  logic [LIMIT_W-1:0] lim_q;
  logic [LIMIT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = '0;
    end else if (run && !hit) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (load) begin
        lim_q <= limit;
      end
    end
  end

  assign hit = run && (cnt_q == lim_q);

endmodule

// File: rtl/wcp_poll_ctrl.sv
module wcp_poll_ctrl
  import wcp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LIMIT_W    = 16,
  parameter int unsigned SETTLE_CYC = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               mode_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         exp_data_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               rd_req_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic               rd_ack_i,
  input  logic [7:0]         rd_data_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o
);

  localparam bit SKIP_SETTLE = (SETTLE_CYC == 0);

  logic              rst_sync_n;
  wcp_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] exp_q;
  wcp_mode_e         mode_q;
  logic              done_q, done_d;
  logic              to_q, to_d;

  logic busy, accept, poll_ack, conf_ack, complete;
  logic candidate, full_match, clr_hist;
  logic settle_load, settle_run, settle_done, limit_hit;

  wcp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign busy        = (state_q != ST_IDLE);
  assign accept      = (state_q == ST_IDLE) && start_i;
  assign poll_ack    = (state_q == ST_POLL) && rd_ack_i;
  assign conf_ack    = ((state_q == ST_CONF_A) || (state_q == ST_CONF_B)) && rd_ack_i;
  assign complete    = (state_q == ST_CONF_B) && rd_ack_i && full_match;
  assign clr_hist    = accept || (conf_ack && !full_match);
  assign settle_load = poll_ack && candidate;
  assign settle_run  = (state_q == ST_SETTLE);

  wcp_match_eval u_eval (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode       (mode_q),
    .exp_byte   (exp_q),
    .rd_byte    (rd_data_i),
    .capture    (poll_ack),
    .clr_hist   (clr_hist),
    .candidate  (candidate),
    .full_match (full_match)
  );

  wcp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (settle_load),
    .run     (settle_run),
    .expired (settle_done)
  );

  wcp_limit_counter #(.LIMIT_W(LIMIT_W)) u_limit (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (accept),
    .limit (limit_i),
    .run   (busy),
    .hit   (limit_hit)
  );

  // Next-state process
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    to_d    = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_d = ST_POLL;
      end
    end else if (complete) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
    end else if (limit_hit) begin
      state_d = ST_IDLE;
      to_d    = 1'b1;
    end else begin
      unique case (state_q)
        ST_POLL: begin
          if (rd_ack_i && candidate) begin
            if (SKIP_SETTLE || (mode_q == MODE_TOGGLE)) begin
              state_d = ST_CONF_A;
            end else begin
              state_d = ST_SETTLE;
            end
          end
        end
        ST_SETTLE: begin
          if (settle_done) begin
            state_d = ST_CONF_A;
          end
        end
        ST_CONF_A: begin
          if (rd_ack_i) begin
            state_d = full_match ? ST_CONF_B : ST_POLL;
          end
        end
        ST_CONF_B: begin
          if (rd_ack_i) begin
            state_d = ST_POLL;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      exp_q   <= '0;
      mode_q  <= MODE_DATA;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      to_q    <= to_d;
      if (accept) begin
        addr_q <= addr_i;
        exp_q  <= exp_data_i;
        mode_q <= wcp_mode_e'(mode_i);
      end
    end
  end

  assign rd_req_o  = (state_q == ST_POLL) || (state_q == ST_CONF_A) || (state_q == ST_CONF_B);
  assign rd_addr_o = addr_q;
  assign busy_o    = busy;
  assign done_o    = done_q;
  assign timeout_o = to_q;

endmodule

// File: rtl/wcp_poll_checker.sv
module wcp_poll_checker #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic              done_o,
  input logic              timeout_o
);

  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_o);

  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!busy_o || $stable(rd_addr_o)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(rd_ack_i) && !busy_o));

  a_r9_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));

  a_r9_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!busy_o ##1 !timeout_o));

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i && busy_o) |=> (rd_req_o || done_o || timeout_o));

endmodule

bind wcp_poll_ctrl wcp_poll_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .busy_o    (busy_o),
  .rd_req_o  (rd_req_o),
  .rd_addr_o (rd_addr_o),
  .rd_ack_i  (rd_ack_i),
  .done_o    (done_o),
  .timeout_o (timeout_o)
);

// File: tb/wcp_poll_ctrl_tb_top.sv
module wcp_poll_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 16;
  localparam int SETTLE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    exp_data_i = '0;
  logic [LW-1:0] limit_i = '0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_ack_i;
  logic [7:0]    rd_data_i;
  logic          busy_o, done_o, timeout_o;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wcp_poll_ctrl #(.ADDR_W(AW), .LIMIT_W(LW), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .addr_i(addr_i), .exp_data_i(exp_data_i), .limit_i(limit_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  // Memory responder: acknowledges one cycle after a request appears.
  byte unsigned mem_q[$];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack_i  <= 1'b0;
      rd_data_i <= 8'h00;
    end else if (rd_req_o && !rd_ack_i) begin
      rd_ack_i  <= 1'b1;
      rd_data_i <= (mem_q.size() > 0) ? mem_q.pop_front() : 8'h00;
    end else begin
      rd_ack_i <= 1'b0;
    end
  end

  // Behavioural reference model. Phase: 0 idle, 1 poll, 2 settle, 3 first confirm, 4 second confirm.
  int          m_phase;
  int          m_cnt, m_lim, m_sc;
  bit          m_mode, m_hv, m_prev, m_done, m_to;
  logic [AW-1:0] m_addr;
  logic [7:0]  m_exp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_done = 0; m_to = 0; m_hv = 0; m_prev = 0;
      m_cnt = 0; m_lim = 0; m_sc = 0; m_addr = '0; m_exp = '0; m_mode = 0;
    end else begin
      m_done = 0; m_to = 0;
      if (m_phase == 0) begin
        if (start_i) begin
          m_addr = addr_i; m_exp = exp_data_i; m_mode = mode_i;
          m_lim = int'(limit_i); m_cnt = 0; m_hv = 0; m_phase = 1;
        end
      end else if (m_phase == 4 && rd_ack_i && rd_data_i == m_exp) begin
        m_done = 1; m_phase = 0;
      end else if (m_cnt == m_lim) begin
        m_to = 1; m_phase = 0;
      end else begin
        m_cnt++;
        case (m_phase)
          1: if (rd_ack_i) begin
               if (!m_mode) begin
                 if (rd_data_i[7] == m_exp[7]) begin
                   m_phase = (SETTLE == 0) ? 3 : 2; m_sc = 0;
                 end
               end else if (m_hv && rd_data_i[6] == m_prev) begin
                 m_phase = 3;
               end else begin
                 m_prev = rd_data_i[6]; m_hv = 1;
               end
             end
          2: if (m_sc == SETTLE - 1) m_phase = 3; else m_sc++;
          3: if (rd_ack_i) begin
               if (rd_data_i == m_exp) m_phase = 4;
               else begin m_phase = 1; m_hv = 0; end
             end
          4: if (rd_ack_i) begin m_phase = 1; m_hv = 0; end
          default: m_phase = 0;
        endcase
      end
    end
  end

  // Cycle compare against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (busy_o !== (m_phase != 0)) begin
        errors++; $display("FAIL R2 busy_o: actual %0b expected %0b", busy_o, m_phase != 0);
      end
      if (rd_req_o !== (m_phase == 1 || m_phase == 3 || m_phase == 4)) begin
        errors++; $display("FAIL R4/R10 rd_req_o: actual %0b expected %0b phase %0d", rd_req_o, rd_req_o === 1'b0, m_phase);
      end
      if (rd_req_o && rd_addr_o !== m_addr) begin
        errors++; $display("FAIL R2 rd_addr_o: actual %h expected %h", rd_addr_o, m_addr);
      end
      if (done_o !== m_done) begin
        errors++; $display("FAIL R6/R8 done_o: actual %0b expected %0b", done_o, m_done);
      end
      if (timeout_o !== m_to) begin
        errors++; $display("FAIL R9 timeout_o: actual %0b expected %0b", timeout_o, m_to);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Runs one operation; optional stray start with another address while busy.
  task automatic run_op(input bit mode, input logic [7:0] expb, input logic [AW-1:0] addr,
                        input int lim, input bit stray,
                        output int blen, output int ndone, output int nto);
    bit seen;
    blen = 0; ndone = 0; nto = 0; seen = 0;
    @(negedge clk);
    mode_i = mode; exp_data_i = expb; addr_i = addr; limit_i = LW'(lim); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (busy_o) blen++;
      if (done_o) ndone++;
      if (timeout_o) nto++;
      if (done_o || timeout_o) seen = 1;
      if (stray && blen == 3) begin
        start_i = 1'b1; addr_i = ~addr; mode_i = ~mode; limit_i = '0;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      if (seen && !done_o && !timeout_o) break;
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bl, nd, nt;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1 busy in reset", int'(busy_o), 0);
    check("R1 req in reset", int'(rd_req_o), 0);
    check("R1 done/timeout in reset", int'(done_o | timeout_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    check("R1 idle after reset", int'(busy_o | rd_req_o), 0);

    // R3 R4 R6 R8: data-poll, one miss then candidate, settle, two confirms
    mem_q = '{8'h00, 8'h80, 8'hA5, 8'hA5};
    run_op(1'b0, 8'hA5, 16'h1200, 200, 1'b0, bl, nd, nt);
    check("R3/R4 data-poll busy length", bl, 8 + SETTLE);
    check("R6 data-poll done", nd, 1);
    check("R8 no timeout", nt, 0);
    check("R3 reads consumed", mem_q.size(), 0);

    // R7: data-poll rejection then success
    mem_q = '{8'h85, 8'h25, 8'hA5, 8'hA5, 8'hA5};
    run_op(1'b0, 8'hA5, 16'h0042, 200, 1'b0, bl, nd, nt);
    check("R7 data-poll reject busy length", bl, 10 + 2*SETTLE);
    check("R7 data-poll reject done", nd, 1);

    // R5 R6: toggle mode
    mem_q = '{8'h40, 8'h00, 8'h40, 8'h40, 8'h3C, 8'h3C};
    run_op(1'b1, 8'h3C, 16'hBEEF, 200, 1'b0, bl, nd, nt);
    check("R5 toggle busy length", bl, 12);
    check("R5 toggle done", nd, 1);

    // R7: toggle rejection clears bit-6 history
    mem_q = '{8'h40, 8'h40, 8'h11, 8'h40, 8'h40, 8'h3C, 8'h3C};
    run_op(1'b1, 8'h3C, 16'h0007, 200, 1'b0, bl, nd, nt);
    check("R7 toggle reject busy length", bl, 14);
    check("R7 toggle reject done", nd, 1);
    check("R7 toggle reads consumed", mem_q.size(), 0);

    // R9: timeout with limit 9, no completion ever
    mem_q = {};
    run_op(1'b0, 8'h80, 16'h3333, 9, 1'b0, bl, nd, nt);
    check("R9 timeout busy length", bl, 10);
    check("R9 timeout pulse", nt, 1);
    check("R9 no done on timeout", nd, 0);
    repeat (2) @(negedge clk);

    // R9 boundary: completion in last allowed cycle wins
    mem_q = '{8'h00, 8'h80, 8'hA5, 8'hA5};
    run_op(1'b0, 8'hA5, 16'h1200, 7 + SETTLE, 1'b0, bl, nd, nt);
    check("R9 completion at limit wins", nd, 1);
    check("R9 no timeout at limit", nt, 0);

    // R9 boundary: one cycle short times out
    mem_q = '{8'h00, 8'h80, 8'hA5, 8'hA5};
    run_op(1'b0, 8'hA5, 16'h1200, 6 + SETTLE, 1'b0, bl, nd, nt);
    check("R9 one short times out", nt, 1);
    check("R9 one short busy length", bl, 7 + SETTLE);
    mem_q = {};
    repeat (3) @(negedge clk);

    // R2: stray start while busy has no effect
    mem_q = '{8'h00, 8'h80, 8'hA5, 8'hA5};
    run_op(1'b0, 8'hA5, 16'h5A5A, 200, 1'b1, bl, nd, nt);
    check("R2 stray start busy length", bl, 8 + SETTLE);
    check("R2 stray start done", nd, 1);
    check("R2 address kept", int'(rd_addr_o), 16'h5A5A);
    repeat (3) @(negedge clk);
    check("R2 stray start not queued", int'(busy_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule